// File: doc/BRIEF.md
# SDRAM Refresh Request Scheduler

This block decides when a memory controller has to issue SDRAM refresh commands, and it drives the device clock-enable level. A down-counter measures the refresh period. The period is the programmed interval value plus a fixed offset of 50 clock cycles. A two-bit mode selects one of four behaviours: refresh off, one command per period, a group of 4 commands per period, or a group of 8 commands per period. Each period expiry adds the group size to a saturating pending counter. The refresh request stays high while that counter is non-zero. The command sequencer pulses an acknowledge for one cycle for every refresh command it issues, and each pulse takes one command off the counter.

The configuration fields are plain level inputs, held by a register outside the block. The block keeps a registered copy of the mode and interval. When either field differs from that copy, the period counter restarts from the new value. Two further functions sit beside the scheduler. Power-down gating holds CKE high only while a transaction is active. Self-refresh requests entry whenever the device is idle and has no refresh work left; an access pulls the device out, and entry is requested again once the access ends.

The request/acknowledge pair is a level request with a single-cycle acknowledge, so there is no data stream and no back-pressure. The request simply remains high until enough acknowledges have arrived. All outputs are registered. Everything is synchronous to one clock, with a synchronous active-high reset.

Top module: `rfs_sched`

## Requirements
- R1: While reset is high, and on the first cycle after it, ref_req and sr_req are 0 and cke is 1. The mode copy resets to off and the interval copy resets to 0x6188.
- R2: While cfg_mode is 2'b00 (off), ref_req stays 0, and pulses on ref_ack have no effect.
- R3: With cfg_mode 2'b01, ref_req rises cfg_interval+50 cycles after the cycle in which the configuration changed. Later expiries follow every cfg_interval+50 cycles. Each expiry adds one command, and one ref_ack clears it.
- R4: With cfg_mode 2'b10, one expiry adds 4 commands. ref_req stays high until exactly 4 ref_ack pulses have been taken, one command per pulse.
- R5: With cfg_mode 2'b11, one expiry adds 8 commands. ref_req stays high until exactly 8 ref_ack pulses have been taken.
- R6: When an expiry arrives while commands are still pending, the new commands are added to the pending count, and the count saturates at 2^PEND_W-1 (31 by default) rather than wrapping.
- R7: A change of cfg_interval or cfg_mode restarts the period counter. The next expiry comes new_interval+50 cycles after the change, wherever the old count stood.
- R8: Setting cfg_mode to 2'b00 empties the pending count. ref_req is 0 on the cycle after the edge that samples the change.
- R9: A ref_ack pulse while ref_req is 0 is ignored: the pending count does not wrap, and ref_req stays 0.
- R10: With cfg_pwrdn_en set, cke equals txn_active delayed by one cycle. With both cfg_pwrdn_en and cfg_selfref_en clear, cke is 1.
- R11: With cfg_selfref_en set, sr_req is high one cycle after a cycle in which txn_active is 0 and no refresh is pending. Otherwise sr_req is low, so an access brings the device out and entry is requested again afterwards. While sr_req is high, cke is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Refresh mode: 00 off, 01 single, 10 group of 4, 11 group of 8 |
| cfg_interval | input | IV_W (16) | Programmed interval; the period is this value plus 50 cycles |
| cfg_pwrdn_en | input | 1 | Power-down gating of CKE |
| cfg_selfref_en | input | 1 | Self-refresh entry enable |
| ref_ack | input | 1 | One-cycle pulse per refresh command issued |
| txn_active | input | 1 | A memory transaction is in progress |
| ref_req | output | 1 | Refresh request, high while commands are pending |
| sr_req | output | 1 | Self-refresh entry request |
| cke | output | 1 | Clock-enable level for the device |

## Verification
The period is measured in single mode with a short interval. It is then measured again after the interval is rewritten in mid-count, and again after only the mode is rewritten. A restart in the wrong cycle shows up as a period that is too short or too long. In both group modes the bench counts the acknowledges needed to drop the request, which separates the group sizes 1, 4 and 8. The bench then lets many periods pass without any acknowledge, so a counter that wraps instead of saturating would release after the wrong number of pulses. Stray acknowledges, the switch to off while commands are pending, and the CKE and self-refresh levels across transaction edges are each checked one cycle after their stimulus.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  typedef enum logic [1:0] {
    RM_OFF    = 2'b00,
    RM_SINGLE = 2'b01,
    RM_GRP4   = 2'b10,
    RM_GRP8   = 2'b11
  } rmode_e;

  localparam int unsigned PERIOD_OFFSET = 50;

  // number of refresh commands added by one period expiry
  function automatic int unsigned group_len(rmode_e m);
    case (m)
      RM_SINGLE: return 1;
      RM_GRP4:   return 4;
      RM_GRP8:   return 8;
      default:   return 0;
    endcase
  endfunction

endpackage

// File: rtl/rfs_cfg_track.sv
module rfs_cfg_track
  import rfs_pkg::*;
#(
  parameter int unsigned IV_W = 16,
  parameter logic [IV_W-1:0] RST_IV = 16'h6188
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      mode_in,
  input  logic [IV_W-1:0] iv_in,
  output rmode_e          mode_q,
  output logic            changed
);

  logic [IV_W-1:0] iv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= RM_OFF;
      iv_q   <= RST_IV;
    end else begin
      mode_q <= rmode_e'(mode_in);
      iv_q   <= iv_in;
    end
  end

  // a rewrite of either field restarts the period
  assign changed = (rmode_e'(mode_in) != mode_q) || (iv_in != iv_q);

endmodule

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer #(
  parameter int unsigned IV_W   = 16,
  parameter int unsigned OFFSET = 50,
  parameter logic [IV_W-1:0] RST_IV = 16'h6188
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reload,
  input  logic            run,
  input  logic [IV_W-1:0] interval,
  output logic            expire
);

  localparam int unsigned CW = IV_W + 1;
  localparam logic [CW-1:0] OFS_M1  = CW'(OFFSET - 1);
  localparam logic [CW-1:0] RST_CNT = CW'(RST_IV) + OFS_M1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] load_val;

  assign load_val = CW'(interval) + OFS_M1;
  assign expire   = run && !reload && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= RST_CNT;
    end else if (reload) begin
      cnt_q <= load_val;
    end else if (run) begin
      if (cnt_q == '0) cnt_q <= load_val;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/rfs_pend_ctr.sv
module rfs_pend_ctr #(
  parameter int unsigned PW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          add_en,
  input  logic [PW-1:0] add_amt,
  input  logic          take,
  output logic [PW-1:0] pend_q,
  output logic          busy
);

  localparam logic [PW:0] MAXV = {1'b0, {PW{1'b1}}};

  logic          take_eff;
  logic [PW:0]   sum;
  logic [PW-1:0] pend_d;

  assign busy     = (pend_q != '0);
  assign take_eff = take && busy;

  always_comb begin
    sum = {1'b0, pend_q};
    if (add_en)   sum = sum + {1'b0, add_amt};
    if (take_eff) sum = sum - 1'b1;
    if (clear)         pend_d = '0;
    else if (sum > MAXV) pend_d = MAXV[PW-1:0];
    else               pend_d = sum[PW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_d;
  end

endmodule

// File: rtl/rfs_power_ctl.sv
module rfs_power_ctl (
  input  logic clk,
  input  logic rst,
  input  logic pwrdn_en,
  input  logic selfref_en,
  input  logic txn_active,
  input  logic ref_busy,
  output logic sr_req,
  output logic cke
);

  logic sr_d;
  logic cke_d;

  always_comb begin
    sr_d  = selfref_en && !txn_active && !ref_busy;
    cke_d = txn_active || (!pwrdn_en && !sr_d);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_req <= 1'b0;
      cke    <= 1'b1;
    end else begin
      sr_req <= sr_d;
      cke    <= cke_d;
    end
  end

endmodule

// File: rtl/rfs_sched.sv
module rfs_sched
  import rfs_pkg::*;
#(
  parameter int unsigned IV_W   = 16,
  parameter int unsigned PEND_W = 5,   // at least 4, to hold one group of 8
  parameter logic [IV_W-1:0] RST_IV = 16'h6188
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      cfg_mode,
  input  logic [IV_W-1:0] cfg_interval,
  input  logic            cfg_pwrdn_en,
  input  logic            cfg_selfref_en,
  input  logic            ref_ack,
  input  logic            txn_active,
  output logic            ref_req,
  output logic            sr_req,
  output logic            cke
);

  rmode_e          mode_q;
  logic            cfg_changed;
  logic            expire;
  logic            ref_busy;
  logic [PEND_W-1:0] pend_level;
  logic [PEND_W-1:0] grp_amt;

  rfs_cfg_track #(.IV_W(IV_W), .RST_IV(RST_IV)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .mode_in (cfg_mode),
    .iv_in   (cfg_interval),
    .mode_q  (mode_q),
    .changed (cfg_changed)
  );

  rfs_interval_timer #(.IV_W(IV_W), .OFFSET(PERIOD_OFFSET), .RST_IV(RST_IV)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .reload   (cfg_changed),
    .run      (mode_q != RM_OFF),
    .interval (cfg_interval),
    .expire   (expire)
  );

  assign grp_amt = PEND_W'(group_len(mode_q));

  rfs_pend_ctr #(.PW(PEND_W)) u_pend (
    .clk     (clk),
    .rst     (rst),
    .clear   (rmode_e'(cfg_mode) == RM_OFF),
    .add_en  (expire),
    .add_amt (grp_amt),
    .take    (ref_ack),
    .pend_q  (pend_level),
    .busy    (ref_busy)
  );

  assign ref_req = ref_busy;

  rfs_power_ctl u_pwr (
    .clk        (clk),
    .rst        (rst),
    .pwrdn_en   (cfg_pwrdn_en),
    .selfref_en (cfg_selfref_en),
    .txn_active (txn_active),
    .ref_busy   (ref_busy),
    .sr_req     (sr_req),
    .cke        (cke)
  );

endmodule

// File: rtl/rfs_sched_chk.sv
module rfs_sched_chk #(
  parameter int unsigned PEND_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        cfg_mode,
  input logic              cfg_pwrdn_en,
  input logic              ref_ack,
  input logic              txn_active,
  input logic              ref_req,
  input logic              sr_req,
  input logic              cke,
  input logic [PEND_W-1:0] pend_level
);

  localparam logic [PEND_W-1:0] PMAX = {PEND_W{1'b1}};

  a_r1_reset_outputs: assert property (@(posedge clk)
    rst |=> (!ref_req && !sr_req && cke));

  a_r2_off_no_req: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == 2'b00) |=> !ref_req);

  // R4 and R5: the request drops only on an acknowledge or a switch to off
  a_r4_req_held: assert property (@(posedge clk) disable iff (rst)
    (ref_req && !ref_ack && cfg_mode != 2'b00) |=> ref_req);

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (pend_level == PMAX && !ref_ack && cfg_mode != 2'b00) |=> (pend_level == PMAX));

  a_r10_cke_tracks_txn: assert property (@(posedge clk) disable iff (rst)
    cfg_pwrdn_en |=> (cke == $past(txn_active)));

  a_r11_no_sr_during_txn: assert property (@(posedge clk) disable iff (rst)
    txn_active |=> (!sr_req && cke));

  a_r11_sr_cke_low: assert property (@(posedge clk) disable iff (rst)
    sr_req |-> !cke);

endmodule

bind rfs_sched rfs_sched_chk #(.PEND_W(PEND_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_mode     (cfg_mode),
  .cfg_pwrdn_en (cfg_pwrdn_en),
  .ref_ack      (ref_ack),
  .txn_active   (txn_active),
  .ref_req      (ref_req),
  .sr_req       (sr_req),
  .cke          (cke),
  .pend_level   (pend_level)
);

// File: tb/sim_rfs_sched.sv
`timescale 1ns/1ps
module sim_rfs_sched;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_mode = 2'b00;
  logic [15:0] cfg_interval = 16'h6188;
  logic        cfg_pwrdn_en = 1'b0;
  logic        cfg_selfref_en = 1'b0;
  logic        ref_ack = 1'b0;
  logic        txn_active = 1'b0;
  logic        ref_req, sr_req, cke;

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rfs_sched u0 (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_interval(cfg_interval),
    .cfg_pwrdn_en(cfg_pwrdn_en), .cfg_selfref_en(cfg_selfref_en),
    .ref_ack(ref_ack), .txn_active(txn_active),
    .ref_req(ref_req), .sr_req(sr_req), .cke(cke)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [1:0] m, input logic [15:0] iv, input logic pd, input logic sr);
    cfg_mode = m; cfg_interval = iv; cfg_pwrdn_en = pd; cfg_selfref_en = sr;
  endtask

  // apply a configuration at a negedge; return the cycle count just after the sampling edge
  task automatic apply(input logic [1:0] m, input logic [15:0] iv, output int c0);
    set_cfg(m, iv, cfg_pwrdn_en, cfg_selfref_en);
    @(negedge clk);
    c0 = cyc;
  endtask

  task automatic wait_rise(output int at);
    while (!ref_req) @(negedge clk);
    at = cyc;
  endtask

  task automatic ack_until_low(output int n);
    n = 0;
    while (ref_req && n < 100) begin
      ref_ack = 1'b1;
      @(negedge clk);
      ref_ack = 1'b0;
      n++;
    end
  endtask

  task automatic idle_off();
    int c;
    apply(2'b00, 16'd0, c);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "ref_req in reset", int'(ref_req), 0);
    check("R1", "sr_req in reset", int'(sr_req), 0);
    check("R1", "cke in reset", int'(cke), 1);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "ref_req after reset", int'(ref_req), 0);
    check("R1", "cke after reset", int'(cke), 1);
  endtask

  task automatic t_off();
    int hits = 0;
    int c;
    apply(2'b00, 16'd0, c);
    for (int i = 0; i < 300; i++) begin
      ref_ack = (i % 7 == 0);
      @(negedge clk);
      if (ref_req) hits++;
    end
    ref_ack = 1'b0;
    check("R2", "requests while off", hits, 0);
  endtask

  task automatic t_single();
    int c0, r1, r2;
    idle_off();
    apply(2'b01, 16'd5, c0);
    wait_rise(r1);
    check("R3", "first period", r1 - c0, 55);
    ref_ack = 1'b1; @(negedge clk); ref_ack = 1'b0;
    check("R3", "one ack clears single", int'(ref_req), 0);
    ref_ack = 1'b1; @(negedge clk); ref_ack = 1'b0;
    check("R9", "stray ack leaves req low", int'(ref_req), 0);
    wait_rise(r2);
    check("R3", "steady period", r2 - r1, 55);
    ref_ack = 1'b1; @(negedge clk); ref_ack = 1'b0;
    check("R9", "count did not wrap", int'(ref_req), 0);
  endtask

  task automatic t_group(input logic [1:0] m, input int expn, input string req);
    int c0, r, n;
    idle_off();
    apply(m, 16'd0, c0);
    wait_rise(r);
    check(req, "group period", r - c0, 50);
    ack_until_low(n);
    check(req, "acks per group", n, expn);
  endtask

  task automatic t_saturate();
    int c0, n;
    idle_off();
    apply(2'b11, 16'd0, c0);
    repeat (270) @(negedge clk);
    apply(2'b11, 16'd1000, c0);
    ack_until_low(n);
    check("R6", "saturated pending count", n, 31);
  endtask

  task automatic t_reload();
    int c0, c1, r;
    idle_off();
    apply(2'b01, 16'd100, c0);
    repeat (80) @(negedge clk);
    apply(2'b01, 16'd20, c1);
    wait_rise(r);
    check("R7", "restart on interval rewrite", r - c1, 70);
    ref_ack = 1'b1; @(negedge clk); ref_ack = 1'b0;
    idle_off();
    apply(2'b01, 16'd30, c0);
    repeat (40) @(negedge clk);
    apply(2'b10, 16'd30, c1);
    wait_rise(r);
    check("R7", "restart on mode rewrite", r - c1, 80);
  endtask

  task automatic t_clear();
    int c0, r, n;
    idle_off();
    apply(2'b10, 16'd0, c0);
    wait_rise(r);
    ref_ack = 1'b1; @(negedge clk); ref_ack = 1'b0;
    apply(2'b00, 16'd0, c0);
    check("R8", "req after switch to off", int'(ref_req), 0);
    apply(2'b10, 16'd0, c0);
    wait_rise(r);
    ack_until_low(n);
    check("R8", "no leftover commands", n, 4);
  endtask

  task automatic t_power();
    idle_off();
    txn_active = 1'b0;
    set_cfg(2'b00, 16'd0, 1'b1, 1'b0);
    @(negedge clk);
    check("R10", "cke idle with power-down", int'(cke), 0);
    txn_active = 1'b1; @(negedge clk);
    check("R10", "cke during transaction", int'(cke), 1);
    txn_active = 1'b0; @(negedge clk);
    check("R10", "cke after transaction", int'(cke), 0);
    set_cfg(2'b00, 16'd0, 1'b0, 1'b0); @(negedge clk);
    check("R10", "cke with power-down off", int'(cke), 1);
  endtask

  task automatic t_selfref();
    int r;
    idle_off();
    txn_active = 1'b0;
    set_cfg(2'b00, 16'd0, 1'b0, 1'b1);
    @(negedge clk);
    check("R11", "entry when idle", int'(sr_req), 1);
    check("R11", "cke low in self-refresh", int'(cke), 0);
    txn_active = 1'b1; @(negedge clk);
    check("R11", "exit on access", int'(sr_req), 0);
    txn_active = 1'b0; @(negedge clk);
    check("R11", "re-entry after access", int'(sr_req), 1);
    set_cfg(2'b01, 16'd0, 1'b0, 1'b1);
    wait_rise(r);
    @(negedge clk);
    check("R11", "no entry with refresh pending", int'(sr_req), 0);
    ref_ack = 1'b1; @(negedge clk); ref_ack = 1'b0;
    @(negedge clk);
    check("R11", "entry after refresh done", int'(sr_req), 1);
    set_cfg(2'b00, 16'd0, 1'b0, 1'b0);
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_off();
    t_single();
    t_group(2'b10, 4, "R4");
    t_group(2'b11, 8, "R5");
    t_saturate();
    t_reload();
    t_clear();
    t_power();
    t_selfref();
    t_group(2'b01, 1, "R3");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule